// File: doc/BRIEF.md
# Sparse-Ones Pipelined Shift-Add Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product. It does not add a partial product for every multiplier bit. Instead, it first counts the set bits in each operand and treats the sparser one as the effective multiplier. A position analyzer then extracts the indices of up to three set bits in that operand. Each extracted index selects a copy of the other operand, shifted left by that index. The shifted copies are summed over three addition stages, one addition per clock.

Operands whose effective multiplier has more than three set bits fall outside the datapath. For these the block returns a zero product and raises an unsupported flag. The pipeline has a fixed five-cycle latency: a swap stage, an analysis stage, then three add stages. It accepts a new operand pair on every clock. A caller presents a pair with a one-cycle valid strobe and collects the product when the output strobe rises five cycles later.

Top module: `sparse_mul`

## Requirements
- R1: For a supported pair, `out_prod` equals `in_mcand * in_mplr` as an unsigned 2N-bit value. For example, 5 and 6 give 30, built as 5 shifted by 1 plus 5 shifted by 2.
- R2: If `in_mcand` has strictly fewer set bits than `in_mplr`, the two operands swap roles before analysis. With equal counts, `in_mplr` stays the effective multiplier. As a result, a dense `in_mplr` paired with a sparse `in_mcand` still gives a correct product with the flag low.
- R3: An effective multiplier with one, two or exactly three set bits gives the exact product. Bit positions are taken from least to most significant, and unused slots add zero.
- R4: If either operand is zero, the product is zero and `out_unsup` is low.
- R5: If both operands have more than three set bits, `out_unsup` is high with `out_valid` and `out_prod` is zero.
- R6: `out_unsup` is never high while `out_valid` is low.
- R7: `out_valid` is high exactly five clock edges after the edge that sampled `in_valid` high, and at no other time.
- R8: Pairs presented on consecutive cycles come out on consecutive cycles, in order, each with its own correct result.
- R9: While `rst_n` is low, `out_valid`, `out_unsup` and `out_prod` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| in_valid | input | 1 | Operand pair is presented this cycle |
| in_mcand | input | OP_W | Multiplicand operand, unsigned |
| in_mplr | input | OP_W | Multiplier operand, unsigned |
| out_valid | output | 1 | Result is presented this cycle |
| out_prod | output | 2*OP_W | Product, or zero when unsupported |
| out_unsup | output | 1 | Effective multiplier had more than three set bits |

## Verification
In the first stage, two decisions come from the same pair of popcounts in the same cycle: whether the roles swap, and whether the unsupported flag is raised. A wrong choice in either one shows up as a flag error or a wrong product. The bench provokes this with pairs that sit on both sides of the three-ones limit in either order: 4 ones against 3 ones, 3 against 4, 5 against 4, and pairs with equal counts. It judges each result by the exact product and the flag value that a reference model, built from the requirements, predicts. The bench also streams back-to-back pairs in which supported and unsupported results alternate, to confirm that the flag and product of one result never spill into its neighbour.

// File: rtl/sparse_mul_pkg.sv
package sparse_mul_pkg;
  // Number of set bits the datapath can expand into shifted terms.
  localparam int SM_TERMS   = 3;
  // Swap stage, analysis stage, then one stage per term.
  localparam int SM_LATENCY = 2 + SM_TERMS;
endpackage

// File: rtl/sm_swap_stage.sv
module sm_swap_stage
  import sparse_mul_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_valid,
  input  logic [OP_W-1:0] a_mcand,
  input  logic [OP_W-1:0] a_mplr,
  output logic            z_valid,
  output logic [OP_W-1:0] z_mcand,
  output logic [OP_W-1:0] z_mplr,
  output logic            z_unsup
);
  localparam int CNT_W = $clog2(OP_W + 1);

  logic [CNT_W-1:0] ones_mcand, ones_mplr, ones_min;
  logic             swap;
  logic [OP_W-1:0]  mcand_d, mplr_d;
  logic             unsup_d;

  always_comb begin
    ones_mcand = '0;
    ones_mplr  = '0;
    for (int i = 0; i < OP_W; i++) begin
      ones_mcand = ones_mcand + CNT_W'(a_mcand[i]);
      ones_mplr  = ones_mplr  + CNT_W'(a_mplr[i]);
    end
    swap     = ones_mcand < ones_mplr;
    ones_min = swap ? ones_mcand : ones_mplr;
    mplr_d   = swap ? a_mcand : a_mplr;
    mcand_d  = swap ? a_mplr  : a_mcand;
    unsup_d  = ones_min > CNT_W'(SM_TERMS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_valid <= 1'b0;
      z_mcand <= '0;
      z_mplr  <= '0;
      z_unsup <= 1'b0;
    end else begin
      z_valid <= a_valid;
      if (a_valid) begin
        z_mcand <= mcand_d;
        z_mplr  <= mplr_d;
        z_unsup <= unsup_d;
      end
    end
  end

  AST_SPARSER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    z_valid |-> ($countones(z_mplr) <= $countones(z_mcand))); // R2

endmodule

// File: rtl/sm_pos_analyzer.sv
module sm_pos_analyzer
  import sparse_mul_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           a_valid,
  input  logic [OP_W-1:0]                a_mcand,
  input  logic [OP_W-1:0]                a_mplr,
  input  logic                           a_unsup,
  output logic                           z_valid,
  output logic [OP_W-1:0]                z_mcand,
  output logic [SM_TERMS-1:0][$clog2(OP_W)-1:0] z_pos,
  output logic [SM_TERMS-1:0]            z_pos_vld,
  output logic                           z_unsup
);
  localparam int POS_W  = $clog2(OP_W);
  localparam int SLOT_W = $clog2(SM_TERMS + 1);

  logic [SM_TERMS-1:0][POS_W-1:0] pos_d;
  logic [SM_TERMS-1:0]            vld_d;
  logic [SLOT_W-1:0]              slot;

  always_comb begin
    pos_d = '0;
    vld_d = '0;
    slot  = '0;
    for (int i = 0; i < OP_W; i++) begin
      if (a_mplr[i] && (slot < SLOT_W'(SM_TERMS))) begin
        pos_d[slot] = POS_W'(i);
        vld_d[slot] = 1'b1;
        slot        = slot + 1'b1;
      end
    end
    if (a_unsup) begin
      vld_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_valid   <= 1'b0;
      z_mcand   <= '0;
      z_pos     <= '0;
      z_pos_vld <= '0;
      z_unsup   <= 1'b0;
    end else begin
      z_valid <= a_valid;
      if (a_valid) begin
        z_mcand   <= a_mcand;
        z_pos     <= pos_d;
        z_pos_vld <= vld_d;
        z_unsup   <= a_unsup;
      end
    end
  end

  AST_SLOTS_FILL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    z_valid |-> ((!z_pos_vld[1] || z_pos_vld[0]) && (!z_pos_vld[2] || z_pos_vld[1]))); // R3

  AST_NO_SLOT_WHEN_UNSUP: assert property (@(posedge clk) disable iff (!rst_n)
    (z_valid && z_unsup) |-> (z_pos_vld == '0)); // R5

endmodule

// File: rtl/sm_add_stage.sv
module sm_add_stage
  import sparse_mul_pkg::*;
#(
  parameter int OP_W = 8,
  parameter int IDX  = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           a_valid,
  input  logic [2*OP_W-1:0]              a_acc,
  input  logic [OP_W-1:0]                a_mcand,
  input  logic [SM_TERMS-1:0][$clog2(OP_W)-1:0] a_pos,
  input  logic [SM_TERMS-1:0]            a_pos_vld,
  input  logic                           a_unsup,
  output logic                           z_valid,
  output logic [2*OP_W-1:0]              z_acc,
  output logic [OP_W-1:0]                z_mcand,
  output logic [SM_TERMS-1:0][$clog2(OP_W)-1:0] z_pos,
  output logic [SM_TERMS-1:0]            z_pos_vld,
  output logic                           z_unsup
);
  localparam int PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] term, acc_d;

  always_comb begin
    term  = a_pos_vld[IDX] ? (PROD_W'(a_mcand) << a_pos[IDX]) : '0;
    acc_d = a_acc + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_valid   <= 1'b0;
      z_acc     <= '0;
      z_mcand   <= '0;
      z_pos     <= '0;
      z_pos_vld <= '0;
      z_unsup   <= 1'b0;
    end else begin
      z_valid <= a_valid;
      if (a_valid) begin
        z_acc     <= acc_d;
        z_mcand   <= a_mcand;
        z_pos     <= a_pos;
        z_pos_vld <= a_pos_vld;
        z_unsup   <= a_unsup;
      end
    end
  end

endmodule

// File: rtl/sparse_mul.sv
module sparse_mul
  import sparse_mul_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_mcand,
  input  logic [OP_W-1:0]   in_mplr,
  output logic              out_valid,
  output logic [2*OP_W-1:0] out_prod,
  output logic              out_unsup
);
  localparam int POS_W  = $clog2(OP_W);
  localparam int PROD_W = 2 * OP_W;

  logic            sw_valid, sw_unsup;
  logic [OP_W-1:0] sw_mcand, sw_mplr;

  logic                           c_valid   [SM_TERMS+1];
  logic [PROD_W-1:0]              c_acc     [SM_TERMS+1];
  logic [OP_W-1:0]                c_mcand   [SM_TERMS+1];
  logic [SM_TERMS-1:0][POS_W-1:0] c_pos     [SM_TERMS+1];
  logic [SM_TERMS-1:0]            c_pos_vld [SM_TERMS+1];
  logic                           c_unsup   [SM_TERMS+1];

  sm_swap_stage #(.OP_W(OP_W)) swap_i (
    .clk(clk), .rst_n(rst_n),
    .a_valid(in_valid), .a_mcand(in_mcand), .a_mplr(in_mplr),
    .z_valid(sw_valid), .z_mcand(sw_mcand), .z_mplr(sw_mplr), .z_unsup(sw_unsup)
  );

  sm_pos_analyzer #(.OP_W(OP_W)) ana_i (
    .clk(clk), .rst_n(rst_n),
    .a_valid(sw_valid), .a_mcand(sw_mcand), .a_mplr(sw_mplr), .a_unsup(sw_unsup),
    .z_valid(c_valid[0]), .z_mcand(c_mcand[0]), .z_pos(c_pos[0]),
    .z_pos_vld(c_pos_vld[0]), .z_unsup(c_unsup[0])
  );

  assign c_acc[0] = '0;

  for (genvar k = 0; k < SM_TERMS; k++) begin : g_add
    sm_add_stage #(.OP_W(OP_W), .IDX(k)) add_i (
      .clk(clk), .rst_n(rst_n),
      .a_valid(c_valid[k]), .a_acc(c_acc[k]), .a_mcand(c_mcand[k]),
      .a_pos(c_pos[k]), .a_pos_vld(c_pos_vld[k]), .a_unsup(c_unsup[k]),
      .z_valid(c_valid[k+1]), .z_acc(c_acc[k+1]), .z_mcand(c_mcand[k+1]),
      .z_pos(c_pos[k+1]), .z_pos_vld(c_pos_vld[k+1]), .z_unsup(c_unsup[k+1])
    );
  end

  assign out_valid = c_valid[SM_TERMS];
  assign out_prod  = c_acc[SM_TERMS];
  assign out_unsup = c_unsup[SM_TERMS] && c_valid[SM_TERMS];

  // Checker state: input history since reset, for latency and zero-operand checks.
  logic [2:0]            since_q;
  logic [SM_LATENCY-1:0] hist_vld_q, hist_zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q     <= '0;
      hist_vld_q  <= '0;
      hist_zero_q <= '0;
    end else begin
      since_q     <= (since_q == 3'(SM_LATENCY)) ? since_q : since_q + 3'd1;
      hist_vld_q  <= {hist_vld_q[SM_LATENCY-2:0], in_valid};
      hist_zero_q <= {hist_zero_q[SM_LATENCY-2:0],
                      in_valid && ((in_mcand == '0) || (in_mplr == '0))};
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == 3'(SM_LATENCY)) |-> (out_valid == hist_vld_q[SM_LATENCY-1])); // R7

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hist_zero_q[SM_LATENCY-1]) |-> (out_prod == '0 && !out_unsup)); // R4

  AST_UNSUP_ZERO_PROD: assert property (@(posedge clk) disable iff (!rst_n)
    out_unsup |-> (out_prod == '0)); // R5

  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_unsup |-> out_valid); // R6

  AST_PROD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_prod <= (PROD_W'(c_mcand[SM_TERMS]) << OP_W))); // R1

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c_pos_vld[SM_TERMS][1]) |->
      (c_pos[SM_TERMS][1] > c_pos[SM_TERMS][0])); // R3

endmodule

// File: tb/sparse_mul_tb_top.sv
module sparse_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W       = 8;
  localparam int PROD_W     = 2 * OP_W;
  localparam int LAT        = 5;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [OP_W-1:0]   in_mcand, in_mplr;
  logic              out_valid;
  logic [PROD_W-1:0] out_prod;
  logic              out_unsup;

  typedef struct {
    logic [PROD_W-1:0] prod;
    logic              unsup;
    int                due;
    string             tag;
  } exp_t;

  exp_t sb_q[$];
  int   cyc      = 0;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   mon_on   = 0;

  sparse_mul #(.OP_W(OP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_mcand(in_mcand), .in_mplr(in_mplr),
    .out_valid(out_valid), .out_prod(out_prod), .out_unsup(out_unsup)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // Driver: present one pair on the next cycle and record its expected result.
  task automatic send(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input string tag);
    exp_t e;
    int   pa, pb, mn;
    @(negedge clk);
    in_valid = 1'b1;
    in_mcand = a;
    in_mplr  = b;
    pa = $countones(a);
    pb = $countones(b);
    mn = (pa < pb) ? pa : pb;
    e.unsup = (mn > 3);
    e.prod  = e.unsup ? '0 : (PROD_W'(a) * PROD_W'(b));
    e.due   = cyc + LAT;
    if (tag != "")            e.tag = tag;
    else if (e.unsup)         e.tag = "R5";
    else if (a == 0 || b == 0) e.tag = "R4";
    else if (pb > 3)          e.tag = "R2";
    else if (mn == 3)         e.tag = "R3";
    else                      e.tag = "R1";
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_mcand = '0;
      in_mplr  = '0;
    end
  endtask

  // Monitor: compare each produced result with the queue head.
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (out_unsup && !out_valid)
        check(1'b0, "R6", "flag without valid", 1, 0);
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7", "unexpected valid", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.due == cyc, "R7", "result cycle", cyc, e.due);
          check(out_prod == e.prod, e.tag, "product", out_prod, e.prod);
          check(out_unsup == e.unsup, e.tag, "unsup flag", out_unsup, e.unsup);
        end
      end else if (sb_q.size() != 0 && sb_q[0].due == cyc) begin
        check(1'b0, "R7", "missing valid", 0, 1);
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_mcand = 8'hFF;
    in_mplr  = 8'h03;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", "valid in reset", out_valid, 0);
    check(out_unsup == 1'b0, "R9", "flag in reset", out_unsup, 0);
    check(out_prod == '0, "R9", "product in reset", out_prod, 0);
    in_valid = 1'b0;
    in_mcand = '0;
    in_mplr  = '0;
    rst_n    = 1'b1;
    mon_on   = 1'b1;
    idle(2);

    send(8'd5, 8'd6, "R1");
    idle(7);
    send(8'h00, 8'hFF, "");
    send(8'hFF, 8'h00, "");
    send(8'h00, 8'h00, "");
    idle(6);
    send(8'h07, 8'hFF, "R2");
    send(8'h03, 8'h55, "R2");
    send(8'h55, 8'h03, "R1");
    send(8'h81, 8'h81, "R1");
    idle(6);
    send(8'hFF, 8'h07, "R3");
    send(8'hE0, 8'hE0, "R3");
    send(8'h0F, 8'h07, "R3");
    send(8'h07, 8'h0F, "R2");
    idle(6);
    send(8'h0F, 8'hF0, "R5");
    send(8'hFF, 8'hFF, "R5");
    send(8'h1F, 8'h0F, "R5");
    idle(6);

    for (int i = 0; i < 60; i++) begin
      logic [OP_W-1:0] a, b;
      a = OP_W'($urandom);
      b = (i % 3 == 0) ? OP_W'($urandom) : OP_W'($urandom & $urandom & $urandom);
      send(a, b, "R8");
    end
    for (int i = 0; i < 20; i++) begin
      send((i % 2) ? 8'hF0 : 8'h24, (i % 2) ? 8'h3C : 8'hC1, "R8");
    end
    idle(LAT + 4);

    check(sb_q.size() == 0, "R7", "results outstanding", sb_q.size(), 0);
    finish_run();
  end

endmodule